// File: doc/BRIEF.md
# Predicated Delayed-Branch Fetch Controller

This block owns the program counter of a wide-issue fetch stage. In every cycle it accepts up to two branch requests that belong to the current issue packet, one per side. Each request carries a 4-bit predicate code and a target word address. The block reads a five-entry predicate register file and evaluates both codes. It resolves the pair into at most one redirect and holds that redirect in a short pipeline. The redirect takes over the fetch address six cycles after its branch issued, so the five packets that follow the branch still execute as delay slots.

When no redirect is due, fetch steps to the first slot of the next packet. A target may point at any word, including a slot inside a packet. In that case the block also drives a kill mask that turns the slots in front of the target into no-ops. Two error flags report a reserved predicate code and the undefined case where both branches of one packet are taken.

Top module: `vliw_branch_fetch`

## Requirements
- R1: While `rst` is high at a rising edge, the fetch address becomes `RESET_VEC` and every pending redirect is discarded.
- R2: When no redirect is due, the fetch address advances each cycle to the next packet: the packet index (`fetch_addr[ADDR_W-1:SLOT_W]`) goes up by one and the slot offset becomes 0.
- R3: The predicate code is decoded as follows. Bits [3:1] select the register. Code 000 always executes and ignores bit 0. Codes 001=B0, 010=B1, 011=B2, 100=A1 and 101=A2 read `pred_file` slice `(select-1)*DATA_W +: DATA_W`. When bit 0 is 1 the branch is taken if that register is zero; when bit 0 is 0 it is taken if the register is non-zero.
- R4: A valid request whose select is 110 or 111 is never taken, and `pred_err` is high in the same cycle.
- R5: Suppose a taken branch is presented in cycle t, that is, sampled at the edge that ends cycle t. Then `fetch_addr` equals its target in cycle t+6, and cycles t+1 to t+5 are not affected by that branch.
- R6: Branches issued in consecutive cycles are all kept, and each one redirects exactly six cycles after its own issue.
- R7: If exactly one of the two requests is taken, its target is used. If neither is taken, no redirect is scheduled.
- R8: If both requests are taken, `both_err` is high in that cycle and the slot-0 target (`br0_target`) is used.
- R9: `kill_mask[i]` is 1 exactly when i < `fetch_addr[SLOT_W-1:0]`.
- R10: A request with its valid bit low has no effect on fetch and never raises `pred_err`, whatever its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_file | input | 5*DATA_W | Predicate registers B0, B1, B2, A1, A2, with B0 in the lowest slice |
| br0_valid | input | 1 | Slot-0 branch present |
| br0_cond | input | 4 | Slot-0 predicate code |
| br0_target | input | ADDR_W | Slot-0 target word address |
| br1_valid | input | 1 | Slot-1 branch present |
| br1_cond | input | 4 | Slot-1 predicate code |
| br1_target | input | ADDR_W | Slot-1 target word address |
| fetch_addr | output | ADDR_W | Current fetch word address |
| kill_mask | output | 2**SLOT_W | Slots to nullify in the fetched packet |
| pred_err | output | 1 | A valid request uses a reserved select |
| both_err | output | 1 | Both requests of the packet are taken |

## Verification
The bench builds the block with ADDR_W=12, SLOT_W=3, DATA_W=8 and a reset vector of 0x040. At this size every one of the 16 predicate codes can be tried against all 32 zero/non-zero patterns of the five predicate registers, on each side. All 256 code pairs can be run through the dual-branch resolution. Because the test branches issue every cycle, the pending-redirect pipeline stays full. A burst of unconditional branches with targets at slot offsets 0 to 7 covers every kill-mask shape.

// File: rtl/vliw_branch_fetch.sv
module vliw_branch_fetch #(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 3,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [5*DATA_W-1:0]   pred_file,
  input  logic                  br0_valid,
  input  logic [3:0]            br0_cond,
  input  logic [ADDR_W-1:0]     br0_target,
  input  logic                  br1_valid,
  input  logic [3:0]            br1_cond,
  input  logic [ADDR_W-1:0]     br1_target,
  output logic [ADDR_W-1:0]     fetch_addr,
  output logic [(1<<SLOT_W)-1:0] kill_mask,
  output logic                  pred_err,
  output logic                  both_err
);
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int STAGES = 5;

  function automatic logic cond_true(input logic [3:0] c, input logic [5*DATA_W-1:0] pf);
    logic [DATA_W-1:0] r;
    r = '0;
    case (c[3:1])
      3'd1: r = pf[0*DATA_W +: DATA_W];
      3'd2: r = pf[1*DATA_W +: DATA_W];
      3'd3: r = pf[2*DATA_W +: DATA_W];
      3'd4: r = pf[3*DATA_W +: DATA_W];
      3'd5: r = pf[4*DATA_W +: DATA_W];
      default: r = '0;
    endcase
    if (c[3:1] == 3'd0)      return 1'b1;
    else if (c[3:1] >= 3'd6) return 1'b0;
    else                     return c[0] ? (r == '0) : (r != '0);
  endfunction

  logic rsv0, rsv1, take0, take1, sel_take;
  logic [ADDR_W-1:0] sel_tgt, pc, pc_seq;
  logic [STAGES-1:0] pv;
  logic [ADDR_W-1:0] pt [STAGES];

  assign rsv0     = br0_valid && (br0_cond[3:1] >= 3'd6);
  assign rsv1     = br1_valid && (br1_cond[3:1] >= 3'd6);
  assign take0    = br0_valid && cond_true(br0_cond, pred_file);
  assign take1    = br1_valid && cond_true(br1_cond, pred_file);
  assign sel_take = take0 || take1;
  assign sel_tgt  = take0 ? br0_target : br1_target;
  assign pred_err = rsv0 || rsv1;
  assign both_err = take0 && take1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv[0] <= 1'b0;
    end else begin
      pv[0] <= sel_take;
    end
    pt[0] <= sel_tgt;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pv[k] <= 1'b0;
      else     pv[k] <= pv[k-1];
      pt[k] <= pt[k-1];
    end
  end

  assign pc_seq = {pc[ADDR_W-1:SLOT_W] + 1'b1, {SLOT_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst)                 pc <= RESET_VEC;
    else if (pv[STAGES-1])   pc <= pt[STAGES-1];
    else                     pc <= pc_seq;
  end

  assign fetch_addr = pc;

  for (genvar i = 0; i < SLOTS; i++) begin : g_kill
    assign kill_mask[i] = pc[SLOT_W-1:0] > SLOT_W'(i);
  end
endmodule

// File: rtl/vliw_branch_fetch_chk.sv
module vliw_branch_fetch_chk #(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 3,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      fetch_addr,
  input logic [(1<<SLOT_W)-1:0] kill_mask,
  input logic                   both_err,
  input logic [ADDR_W-1:0]      br0_target,
  input logic                   sel_take,
  input logic [ADDR_W-1:0]      sel_tgt
);
  logic [2:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)              cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  a_r1_reset_vec: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> fetch_addr == RESET_VEC);

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd6 && !$past(sel_take, 6)) |->
      (fetch_addr[ADDR_W-1:SLOT_W] == $past(fetch_addr[ADDR_W-1:SLOT_W]) + 1'b1 &&
       fetch_addr[SLOT_W-1:0] == '0));

  a_r5_redirect_latency: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd6 && $past(sel_take, 6)) |-> fetch_addr == $past(sel_tgt, 6));

  a_r8_slot0_wins: assert property (@(posedge clk) disable iff (rst)
    both_err |-> (sel_take && sel_tgt == br0_target));

  a_r9_kill_shape: assert property (@(posedge clk) disable iff (rst)
    ($countones(kill_mask) == int'(fetch_addr[SLOT_W-1:0])) &&
    ((kill_mask & (kill_mask + 1'b1)) == '0));
endmodule

bind vliw_branch_fetch vliw_branch_fetch_chk #(
  .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .RESET_VEC(RESET_VEC)
) u_chk (
  .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .kill_mask(kill_mask),
  .both_err(both_err), .br0_target(br0_target),
  .sel_take(sel_take), .sel_tgt(sel_tgt)
);

// File: tb/vliw_branch_fetch_tb.sv
module vliw_branch_fetch_tb;
  localparam int PERIOD = 10;
  localparam int AW = 12;
  localparam int SW = 3;
  localparam int DW = 8;
  localparam logic [AW-1:0] RV = 12'h040;

  logic clk = 1'b0;
  logic rst;
  logic [5*DW-1:0] pred_file;
  logic br0_valid, br1_valid;
  logic [3:0] br0_cond, br1_cond;
  logic [AW-1:0] br0_target, br1_target;
  logic [AW-1:0] fetch_addr;
  logic [7:0] kill_mask;
  logic pred_err, both_err;

  always #(PERIOD/2) clk = ~clk;

  vliw_branch_fetch #(.ADDR_W(AW), .SLOT_W(SW), .DATA_W(DW), .RESET_VEC(RV)) u_dut (
    .clk(clk), .rst(rst), .pred_file(pred_file),
    .br0_valid(br0_valid), .br0_cond(br0_cond), .br0_target(br0_target),
    .br1_valid(br1_valid), .br1_cond(br1_cond), .br1_target(br1_target),
    .fetch_addr(fetch_addr), .kill_mask(kill_mask),
    .pred_err(pred_err), .both_err(both_err));

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic          mv [1:5];
  logic [AW-1:0] mt [1:5];
  logic [AW-1:0] mpc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic exp_take(input logic v, input logic [3:0] c, input logic [5*DW-1:0] pf);
    logic [2:0] s;
    logic [DW-1:0] r;
    s = c[3:1];
    if (!v) return 1'b0;
    if (s == 3'd0) return 1'b1;
    if (s > 3'd5) return 1'b0;
    r = pf[(int'(s)-1)*DW +: DW];
    return c[0] ? (r == 0) : (r != 0);
  endfunction

  function automatic logic [5*DW-1:0] make_pf(input logic [4:0] zmask);
    logic [5*DW-1:0] pf;
    for (int k = 0; k < 5; k++) pf[k*DW +: DW] = zmask[k] ? 8'h00 : 8'(8'h31 + k);
    return pf;
  endfunction

  task automatic tick(input logic r, input logic v0, input logic [3:0] c0, input logic [AW-1:0] t0,
                      input logic v1, input logic [3:0] c1, input logic [AW-1:0] t1, input string tag);
    logic e0, e1, ep, fire;
    logic [AW-1:0] ftg;
    logic [7:0] em;
    rst = r; br0_valid = v0; br0_cond = c0; br0_target = t0;
    br1_valid = v1; br1_cond = c1; br1_target = t1;
    #1;
    e0 = exp_take(v0, c0, pred_file);
    e1 = exp_take(v1, c1, pred_file);
    ep = (v0 && c0[3:1] > 3'd5) || (v1 && c1[3:1] > 3'd5);
    chk(pred_err == ep, (v0 && v1) ? "R4" : (!v0 ? "R10" : "R4"), "pred_err", 32'(pred_err), 32'(ep));
    chk(both_err == (e0 && e1), "R8", "both_err", 32'(both_err), 32'(e0 && e1));
    @(posedge clk);
    if (r) begin
      mpc = RV;
      for (int k = 1; k <= 5; k++) mv[k] = 1'b0;
    end else begin
      fire = mv[5]; ftg = mt[5];
      for (int k = 5; k >= 2; k--) begin mv[k] = mv[k-1]; mt[k] = mt[k-1]; end
      mv[1] = e0 || e1;
      mt[1] = e0 ? t0 : t1;
      mpc = fire ? ftg : {mpc[AW-1:SW] + 1'b1, 3'b000};
    end
    @(negedge clk);
    em = 8'((9'd1 << mpc[2:0]) - 9'd1);
    chk(fetch_addr == mpc, r ? "R1" : tag, "fetch_addr", 32'(fetch_addr), 32'(mpc));
    chk(kill_mask == em, "R9", "kill_mask", 32'(kill_mask), 32'(em));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 4'h0, '0, 1'b0, 4'h0, '0, tag);
  endtask

  initial begin
    pred_file = make_pf(5'b00000);
    tick(1'b1, 0, 0, 0, 0, 0, 0, "R1");
    tick(1'b1, 0, 0, 0, 0, 0, 0, "R1");
    idle(8, "R2");

    // R3, R4, R5: every code against every zero pattern, slot 0 then slot 1
    for (int side = 0; side < 2; side++)
      for (int c = 0; c < 16; c++)
        for (int p = 0; p < 32; p++) begin
          logic [AW-1:0] t;
          pred_file = make_pf(5'(p));
          t = AW'(c * 211 + p * 37 + side * 5);
          if (side == 0) tick(1'b0, 1'b1, 4'(c), t, 1'b0, 4'h0, '0, "R3,R5");
          else           tick(1'b0, 1'b0, 4'h0, '0, 1'b1, 4'(c), t, "R3,R5");
        end
    idle(7, "R2");

    // R7, R8: all code pairs with B0 and B2 zero, B1, A1, A2 non-zero
    pred_file = make_pf(5'b00101);
    for (int c0 = 0; c0 < 16; c0++)
      for (int c1 = 0; c1 < 16; c1++)
        tick(1'b0, 1'b1, 4'(c0), AW'(c0 * 97 + 3), 1'b1, 4'(c1), AW'(c1 * 53 + 800), "R7,R8");
    idle(7, "R2");

    // R6, R9: back-to-back unconditional branches to every slot offset
    for (int k = 0; k < 8; k++)
      tick(1'b0, 1'b1, 4'h0, AW'(12'h300 + k * 8 + k), 1'b0, 4'h0, '0, "R6");
    idle(8, "R6");

    // R1: reset with redirects pending
    for (int k = 0; k < 3; k++)
      tick(1'b0, 1'b1, 4'h0, AW'(12'h500 + k), 1'b0, 4'h0, '0, "R5");
    tick(1'b1, 0, 0, 0, 0, 0, 0, "R1");
    idle(8, "R1");

    // R10: invalid requests with every code
    for (int c = 0; c < 16; c++)
      tick(1'b0, 1'b0, 4'(c), 12'hABC, 1'b0, 4'(15 - c), 12'h123, "R10");
    idle(7, "R10");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule